// File: doc/BRIEF.md
# SAR Converter Conversion Sequencer

This block is the digital half of a charge-redistribution successive-approximation converter. While idle it keeps the converter in acquisition: the top-plate and dummy sampling switches are closed and every capacitor element is tied to the analog inputs. A falling edge on the active-low start input opens the sampling switches. One cycle later it moves the whole array onto the reference nodes. It then runs a binary search, most significant element first. Each trial drives one select bit per element and reads a single comparator bit.

When the last trial resolves, the finished code is registered in straight binary or two's complement. The busy output drops, and a one-cycle valid strobe is raised together with a result-quality flag. In the fast operating mode that flag warns that the result is stale. This happens on the first conversion after reset, or when the gap since the previous accepted start is longer than a configured number of clock cycles. The capacitor array, comparator and reference stay outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: Out of reset and whenever busy_o is low, samp_sw_o=1, in_sel_o=1, elem_ref_o=0, and busy_o=0. Reset clears data_o, data_valid_o and result_ok_o to 0.
- R2: A high-to-low transition of start_n, seen at a clock edge while idle, sets busy_o and clears samp_sw_o at that same edge. in_sel_o stays 1 for one more cycle and falls at the following edge.
- R3: Trials run from bit NBITS-1 down to bit 0, and each trial lasts SETTLE_CYC cycles. During a trial, elem_ref_o holds the bits already decided with the current trial bit set. comp_i is sampled on the trial's last cycle: 1 keeps the bit and 0 clears it.
- R4: busy_o stays high for exactly NBITS*SETTLE_CYC+2 cycles. It falls at the same edge that raises data_valid_o, which stays high for a single cycle.
- R5: twos_sel=0 presents the search result unchanged (straight binary). twos_sel=1 presents it with bit NBITS-1 inverted (two's complement). twos_sel is taken at the edge that ends the conversion.
- R6: The presented code is the result of the sample frozen when samp_sw_o opened in that same conversion. data_o and result_ok_o hold their values until the next valid strobe.
- R7: A falling edge on start_n while busy_o is high is ignored. The conversion neither restarts nor lengthens, and its result is unchanged.
- R8: fast_mode is taken at the accepted start. If it is 1, result_ok_o is 0 for the first conversion after reset. It is also 0 when the count of clock edges from the previous accepted start to this one is greater than IDLE_LIMIT. Otherwise result_ok_o is 1.
- R9: With fast_mode=0 at the accepted start, result_ok_o is 1 whatever the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low convert start; a falling edge begins a conversion |
| comp_i | input | 1 | Comparator result; 1 = sampled input at or above the trial level |
| twos_sel | input | 1 | Output coding: 0 straight binary, 1 two's complement |
| fast_mode | input | 1 | 1 = fast mode with stale-result detection |
| samp_sw_o | output | 1 | 1 = top-plate and dummy sampling switches closed |
| in_sel_o | output | 1 | 1 = all elements on analog inputs; 0 = elements on reference nodes |
| elem_ref_o | output | NBITS | Per-element select when in_sel_o=0: 1 reference, 0 reference ground |
| busy_o | output | 1 | High for the whole conversion |
| data_o | output | NBITS | Last conversion code |
| data_valid_o | output | 1 | One-cycle strobe when a new code is presented |
| result_ok_o | output | 1 | Quality flag of the presented code; 0 = stale |

## Verification
The bench builds the block with NBITS=16, SETTLE_CYC=3 and IDLE_LIMIT=200. The full 16-trial search and the two codings are therefore exercised at full width, while each conversion stays short. A limit of 200 lets the bench place starts exactly 200 and 201 edges apart, which tests both sides of the stale boundary in a few hundred cycles. A production limit would need a wait of a millisecond. The settle count of 3 keeps the trial timer on its counter variant, so the sampling cycle of the comparator lies inside a multi-cycle trial.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      ST_ACQ   = 2'd0,
      ST_OPEN  = 2'd1,
      ST_TRIAL = 2'd2,
      ST_DONE  = 2'd3
   } sar_state_e;

endpackage

// File: rtl/sar_trial_timer.sv
// Marks the last cycle of each bit trial.
module sar_trial_timer #(
   parameter int SETTLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   generate
      if (SETTLE_CYC == 1) begin : g_single
         assign last = run;
      end else begin : g_count
         localparam int TW = $clog2(SETTLE_CYC);
         logic [TW-1:0] tcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tcnt <= '0;
            else if (!run || tcnt == TW'(SETTLE_CYC - 1))
               tcnt <= '0;
            else
               tcnt <= tcnt + 1'b1;
         end
         assign last = run && (tcnt == TW'(SETTLE_CYC - 1));
      end
   endgenerate

endmodule

// File: rtl/sar_approx_reg.sv
// Successive-approximation register with a one-hot trial pointer.
module sar_approx_reg #(
   parameter int NBITS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             comp,
   output logic [NBITS-1:0] trial_o,
   output logic             last_bit_o
);

   localparam logic [NBITS-1:0] TOP = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial_o <= '0;
         ptr     <= '0;
      end else if (load) begin
         trial_o <= TOP;
         ptr     <= TOP;
      end else if (step) begin
         trial_o <= (trial_o & ~ptr) | (comp ? ptr : '0) | (ptr >> 1);
         ptr     <= ptr >> 1;
      end
   end

   assign last_bit_o = ptr[0];

endmodule

// File: rtl/sar_idle_mon.sv
// Measures the gap between accepted starts and latches a stale flag.
module sar_idle_mon #(
   parameter int IDLE_LIMIT = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_acc,
   input  logic fast_mode,
   output logic stale_o
);

   localparam int CW = $clog2(IDLE_LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

   logic [CW-1:0] gap_cnt;
   logic          armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt <= '0;
         armed   <= 1'b0;
         stale_o <= 1'b0;
      end else if (start_acc) begin
         stale_o <= fast_mode & (~armed | (gap_cnt >= LIM));
         gap_cnt <= '0;
         armed   <= 1'b1;
      end else if (gap_cnt != LIM) begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
   parameter int NBITS      = 16,
   parameter int SETTLE_CYC = 4,
   parameter int IDLE_LIMIT = 250000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_n,
   input  logic             comp_i,
   input  logic             twos_sel,
   input  logic             fast_mode,
   output logic             samp_sw_o,
   output logic             in_sel_o,
   output logic [NBITS-1:0] elem_ref_o,
   output logic             busy_o,
   output logic [NBITS-1:0] data_o,
   output logic             data_valid_o,
   output logic             result_ok_o
);

   import sar_pkg::*;

   generate
      if (NBITS < 2) begin : g_bad_nbits
         $error("NBITS must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (IDLE_LIMIT < 1) begin : g_bad_limit
         $error("IDLE_LIMIT must be at least 1");
      end
   endgenerate

   sar_state_e       state;
   logic             start_q;
   logic             accept;
   logic             trial_last;
   logic             step;
   logic             last_bit;
   logic             stale;
   logic [NBITS-1:0] trial;

   assign accept = (state == ST_ACQ) && start_q && !start_n;
   assign step   = (state == ST_TRIAL) && trial_last;

   sar_trial_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_TRIAL),
      .last  (trial_last)
   );

   sar_approx_reg #(.NBITS(NBITS)) u_sar (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (state == ST_OPEN),
      .step       (step),
      .comp       (comp_i),
      .trial_o    (trial),
      .last_bit_o (last_bit)
   );

   sar_idle_mon #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_acc (accept),
      .fast_mode (fast_mode),
      .stale_o   (stale)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_ACQ;
         start_q      <= 1'b1;
         data_o       <= '0;
         data_valid_o <= 1'b0;
         result_ok_o  <= 1'b0;
      end else begin
         start_q      <= start_n;
         data_valid_o <= 1'b0;
         unique case (state)
            ST_ACQ:   if (accept) state <= ST_OPEN;
            ST_OPEN:  state <= ST_TRIAL;
            ST_TRIAL: if (step && last_bit) state <= ST_DONE;
            ST_DONE: begin
               state        <= ST_ACQ;
               data_o       <= trial ^ {twos_sel, {(NBITS-1){1'b0}}};
               data_valid_o <= 1'b1;
               result_ok_o  <= ~stale;
            end
            default:  state <= ST_ACQ;
         endcase
      end
   end

   assign busy_o     = (state != ST_ACQ);
   assign samp_sw_o  = (state == ST_ACQ);
   assign in_sel_o   = (state == ST_ACQ) || (state == ST_OPEN);
   assign elem_ref_o = in_sel_o ? '0 : trial;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
   parameter int NBITS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             samp_sw_o,
   input logic             in_sel_o,
   input logic [NBITS-1:0] elem_ref_o,
   input logic             busy_o,
   input logic [NBITS-1:0] data_o,
   input logic             data_valid_o,
   input logic             result_ok_o
);

   localparam logic [NBITS-1:0] TOPBIT = {1'b1, {(NBITS-1){1'b0}}};

   p_acq_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (samp_sw_o && in_sel_o && elem_ref_o == '0));

   p_open_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(samp_sw_o) |-> (in_sel_o && busy_o));

   p_elem_after_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sel_o) |-> (!samp_sw_o && !$past(samp_sw_o)));

   p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sel_o) |-> (elem_ref_o == TOPBIT));

   p_done_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> data_valid_o);

   p_strobe_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> $fell(busy_o));

   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |=> !data_valid_o);

   p_hold_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid_o |-> ($stable(data_o) && $stable(result_ok_o)));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.NBITS(NBITS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .samp_sw_o    (samp_sw_o),
   .in_sel_o     (in_sel_o),
   .elem_ref_o   (elem_ref_o),
   .busy_o       (busy_o),
   .data_o       (data_o),
   .data_valid_o (data_valid_o),
   .result_ok_o  (result_ok_o)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;

   localparam int N   = 16;
   localparam int S   = 3;
   localparam int LIM = 200;
   localparam int CONV_NEG = N*S + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_n = 1'b1;
   logic         comp;
   logic         twos_sel = 1'b0;
   logic         fast_mode = 1'b0;
   logic         samp_sw, in_sel, busy, dvalid, res_ok;
   logic [N-1:0] elem_ref, dout;

   logic [N-1:0] vin_r = '0;
   logic [N-1:0] held = '0;
   int           cyc = 0;
   int           last_edge = 0;
   int           n_chk = 0;
   int           n_err = 0;
   bit           finished = 0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (samp_sw) held <= vin_r;
   end

   assign comp = (elem_ref <= held);

   sar_conv_ctrl #(.NBITS(N), .SETTLE_CYC(S), .IDLE_LIMIT(LIM)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_n      (start_n),
      .comp_i       (comp),
      .twos_sel     (twos_sel),
      .fast_mode    (fast_mode),
      .samp_sw_o    (samp_sw),
      .in_sel_o     (in_sel),
      .elem_ref_o   (elem_ref),
      .busy_o       (busy),
      .data_o       (dout),
      .data_valid_o (dvalid),
      .result_ok_o  (res_ok)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_gap(input int g);
      while ((cyc + 1) - last_edge < g) @(negedge clk);
   endtask

   // Runs one conversion starting at the current negedge.
   task automatic run_conv(input logic [N-1:0] vin, input logic twos, input logic fast,
                           input bit inject, input bit exp_ok, input bit trace);
      logic [N-1:0] expd;
      bit           busy_ok = 1;
      bit           tr_ok = 1;
      vin_r     = vin;
      twos_sel  = twos;
      fast_mode = fast;
      start_n   = 1'b0;
      last_edge = cyc + 1;
      expd = twos ? (vin ^ {1'b1, {(N-1){1'b0}}}) : vin;
      for (int j = 1; j <= CONV_NEG + 1; j++) begin
         @(negedge clk);
         if (j == 1) begin
            start_n = 1'b1;
            vin_r = ~vin;
            check(busy && !samp_sw && in_sel, "R2 open switches first", {busy, samp_sw, in_sel}, 3'b101);
         end
         if (j == 2)
            check(!in_sel && !samp_sw, "R2 elements leave inputs", {samp_sw, in_sel}, 2'b00);
         if (inject && j == 10) start_n = 1'b0;
         if (inject && j == 11) start_n = 1'b1;
         if (j < CONV_NEG && !busy) busy_ok = 0;
         if (trace && j >= 2 && j < 2 + N*S && (j - 2) % S == 0) begin
            int b = N - 1 - (j - 2) / S;
            logic [N-1:0] m = '1;
            logic [N-1:0] e;
            m = m << (b + 1);
            e = (vin & m) | (N'(1) << b);
            if (elem_ref != e) begin
               tr_ok = 0;
               check(0, "R3 trial code", elem_ref, e);
            end
         end
         if (j == CONV_NEG) begin
            check(busy_ok, "R4 busy held for full conversion", busy_ok, 1);
            check(!busy && dvalid, "R4 busy falls with strobe", {busy, dvalid}, 2'b01);
            check(dout == expd, twos ? "R5 two's complement code" : "R6 straight code of held sample", dout, expd);
            check(res_ok == exp_ok, fast ? "R8 fast-mode quality flag" : "R9 normal-mode quality flag", res_ok, exp_ok);
            if (inject) check(dout == expd && busy_ok, "R7 start while busy ignored", dout, expd);
         end
         if (j == CONV_NEG + 1)
            check(!dvalid && dout == expd, "R4 strobe single cycle, R6 code held", {dvalid, dout}, {1'b0, expd});
      end
      if (trace) check(tr_ok, "R3 MSB-first trial sequence", tr_ok, 1);
   endtask

   task automatic t_reset_state();
      do_reset();
      check(samp_sw && in_sel && elem_ref == 0 && !busy, "R1 acquisition outputs", {samp_sw, in_sel, busy}, 3'b110);
      check(dout == 0 && !dvalid && !res_ok, "R1 reset result registers", {dout, dvalid, res_ok}, 0);
   endtask

   task automatic t_codes();
      run_conv(16'hA53C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      repeat (2) @(negedge clk);
      check(samp_sw && in_sel && elem_ref == 0 && !busy, "R1 back in acquisition", {samp_sw, in_sel, busy}, 3'b110);
      run_conv(16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      run_conv(16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      run_conv(16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      run_conv(16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      run_conv(16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      run_conv(16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_ignore();
      run_conv(16'h5A5A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic t_stale();
      do_reset();
      run_conv(16'h4321, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      run_conv(16'h4322, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      wait_gap(LIM);
      run_conv(16'h4323, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      wait_gap(LIM + 1);
      run_conv(16'h4324, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      wait_gap(LIM * 3);
      run_conv(16'h4325, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      run_conv(16'h4326, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_normal_first();
      do_reset();
      run_conv(16'h0F0F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
   endtask

   initial begin
      t_reset_state();
      t_codes();
      t_ignore();
      t_stale();
      t_normal_first();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule